// File: doc/BRIEF.md
# Multi-Byte CRC-32 / CRC-32C Accumulator Update

This block advances a 32-bit CRC remainder over one to eight bytes packed into a 64-bit data word. The remainder goes in as the low half of a 64-bit accumulator input. Bytes are taken lowest first, starting with bits 7:0, and only as many as the byte count names. A select input picks the IEEE CRC-32 polynomial or the Castagnoli CRC-32C polynomial. The new remainder comes out zero-extended to 64 bits.

The update is the raw reflected shift-register step. The remainder is not inverted on the way in or on the way out. Any message-level seeding with all ones and any final complement is left to the software that chains the calls. Longer messages are handled by feeding each result back in as the next accumulator.

A parameter picks one of two structures. The default is byte-serial: one byte per clock, with a single-cycle `done` pulse and a `busy` flag. The other is a fully unrolled network with a registered result that is ready one cycle after `start`.

Top module: `crc_accum_unit`

## Requirements
- R1: With `poly_sel` = 0 the update uses the reflected polynomial 0xEDB88320. Each byte is XORed into the low 8 bits of the remainder and then shifted least-significant bit first. No complement is applied to the remainder on input or on output.
- R2: With `poly_sel` = 1 the update uses the reflected polynomial 0x82F63B78, with the same bit order and no complement.
- R3: `byte_cnt` is a plain binary count from 1 to 8. Bytes are consumed in little-endian order, starting at `data_in[7:0]`, and only `byte_cnt` bytes are processed.
- R4: Only `acc_in[31:0]` affects the result. `result[63:32]` is always zero.
- R5: In serial mode, `done` is high for exactly one cycle, `byte_cnt` clock cycles after the edge that accepted `start`. The new value appears on `result` in that same cycle.
- R6: In serial mode, `busy` is high from the cycle after an accepted `start` up to the cycle in which `done` rises, where it drops. A `start` seen while `busy` is high is ignored.
- R7: While `rst_n` is low, `done`, `busy` and `result` are all zero.
- R8: `result` changes only in a cycle where `done` is high, and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an update with the operands on the other inputs |
| acc_in | input | 64 | Previous remainder in bits 31:0; bits 63:32 are ignored |
| data_in | input | 64 | Data bytes, little-endian; bytes above the count must be zero |
| byte_cnt | input | 4 | Number of bytes to process, 1 to 8 |
| poly_sel | input | 1 | 0 selects CRC-32, 1 selects CRC-32C |
| result | output | 64 | Updated remainder, zero-extended |
| done | output | 1 | One-cycle pulse when `result` has been updated |
| busy | output | 1 | Serial update in progress |

## Verification
The assertions assume that every accepted `start` carries a `byte_cnt` between 1 and 8. A zero count would make the serial counter wrap around, and that is outside the contract. The stimulus always draws counts from that range and clears every data byte above the count. It also drives random values into the upper accumulator half and issues starts while the block is busy, including long runs with `start` held high. Ignored requests and the dropping of the upper bits therefore both show up at `result`.

// File: rtl/crc_accum_pkg.sv
package crc_accum_pkg;

  localparam int unsigned CRC_W     = 32;
  localparam int unsigned WORD_W    = 64;
  localparam int unsigned LANE_W    = 8;

  // Reflected generator constants (bit 0 is the x^31 coefficient side).
  localparam logic [CRC_W-1:0] POLY_IEEE_REFL = 32'hEDB8_8320;
  localparam logic [CRC_W-1:0] POLY_CAST_REFL = 32'h82F6_3B78;

  typedef enum logic {
    POLY_IEEE = 1'b0,
    POLY_CAST = 1'b1
  } poly_kind_e;

endpackage

// File: rtl/crc_byte_step.sv
// One byte of the reflected CRC recurrence: XOR the byte into the low
// lane, then eight conditional shift-and-reduce stages.
module crc_byte_step #(
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [ACC_W-1:0]  crc_in,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [ACC_W-1:0]  poly,
  output logic [ACC_W-1:0]  crc_out
);

  logic [ACC_W-1:0] stage [BYTE_W+1];

  assign stage[0] = crc_in ^ {{(ACC_W-BYTE_W){1'b0}}, byte_in};

  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    assign stage[b+1] = (stage[b] >> 1) ^ (stage[b][0] ? poly : '0);
  end

  assign crc_out = stage[BYTE_W];

endmodule

// File: rtl/crc_serial_core.sv
// Byte-serial engine: one byte per clock, counted down from byte_cnt.
module crc_serial_core
  import crc_accum_pkg::*;
#(
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ACC_W-1:0]  acc_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic              poly_sel,
  output logic [ACC_W-1:0]  crc_out,
  output logic              done,
  output logic              busy
);

  logic [ACC_W-1:0]  crc_q,  crc_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [CNT_W-1:0]  cnt_q,  cnt_d;
  logic              sel_q,  sel_d;
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [ACC_W-1:0]  res_q,  res_d;
  logic              work_en, res_en, accept;
  logic [ACC_W-1:0]  poly_cur, step_out;

  assign accept   = start & ~busy_q;
  assign poly_cur = (poly_kind_e'(sel_q) == POLY_CAST) ? POLY_CAST_REFL : POLY_IEEE_REFL;

  crc_byte_step #(.ACC_W(ACC_W), .BYTE_W(BYTE_W)) u_step (
    .crc_in (crc_q),
    .byte_in(data_q[BYTE_W-1:0]),
    .poly   (poly_cur),
    .crc_out(step_out)
  );

  // Next-state logic
  always_comb begin
    crc_d   = crc_q;
    data_d  = data_q;
    cnt_d   = cnt_q;
    sel_d   = sel_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    res_d   = res_q;
    work_en = 1'b0;
    res_en  = 1'b0;
    if (accept) begin
      work_en = 1'b1;
      crc_d   = acc_in;
      data_d  = data_in;
      cnt_d   = byte_cnt;
      sel_d   = poly_sel;
      busy_d  = 1'b1;
    end else if (busy_q) begin
      work_en = 1'b1;
      crc_d   = step_out;
      data_d  = data_q >> BYTE_W;
      cnt_d   = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        res_en = 1'b1;
        res_d  = step_out;
      end
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  // Datapath registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      data_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
    end else if (work_en) begin
      crc_q  <= crc_d;
      data_q <= data_d;
      cnt_q  <= cnt_d;
      sel_q  <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  assign crc_out = res_q;
  assign done    = done_q;
  assign busy    = busy_q;

endmodule

// File: rtl/crc_unrolled_core.sv
// Fully unrolled engine: a chain of byte stages, tap picked by byte_cnt,
// result registered one cycle after start.
module crc_unrolled_core
  import crc_accum_pkg::*;
#(
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ACC_W-1:0]  acc_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic              poly_sel,
  output logic [ACC_W-1:0]  crc_out,
  output logic              done,
  output logic              busy
);

  localparam int unsigned NUM_BYTES = DATA_W / BYTE_W;

  logic [ACC_W-1:0] tap [NUM_BYTES+1];
  logic [ACC_W-1:0] poly_cur, pick;
  logic [ACC_W-1:0] res_q, res_d;
  logic             done_q, done_d;

  assign poly_cur = (poly_kind_e'(poly_sel) == POLY_CAST) ? POLY_CAST_REFL : POLY_IEEE_REFL;
  assign tap[0]   = acc_in;

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
    crc_byte_step #(.ACC_W(ACC_W), .BYTE_W(BYTE_W)) u_step (
      .crc_in (tap[i]),
      .byte_in(data_in[i*BYTE_W +: BYTE_W]),
      .poly   (poly_cur),
      .crc_out(tap[i+1])
    );
  end

  always_comb begin
    pick = tap[NUM_BYTES];
    for (int k = 1; k <= NUM_BYTES; k++) begin
      if (byte_cnt == CNT_W'(k)) pick = tap[k];
    end
    done_d = start;
    res_d  = start ? pick : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (start) begin
      res_q <= res_d;
    end
  end

  assign crc_out = res_q;
  assign done    = done_q;
  assign busy    = 1'b0;

endmodule

// File: rtl/crc_accum_unit.sv
module crc_accum_unit
  import crc_accum_pkg::*;
#(
  parameter  int unsigned ACC_W       = CRC_W,
  parameter  int unsigned DATA_W      = WORD_W,
  parameter  int unsigned BYTE_W      = LANE_W,
  parameter  bit          SERIAL_MODE = 1'b1,
  localparam int unsigned NUM_BYTES   = DATA_W / BYTE_W,
  localparam int unsigned CNT_W       = $clog2(NUM_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic              poly_sel,
  output logic [DATA_W-1:0] result,
  output logic              done,
  output logic              busy
);

  logic [ACC_W-1:0] core_res;
  logic             unused_acc_hi;

  assign unused_acc_hi = ^acc_in[DATA_W-1:ACC_W];

  if (SERIAL_MODE) begin : g_serial
    crc_serial_core #(
      .ACC_W(ACC_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)
    ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .acc_in  (acc_in[ACC_W-1:0]),
      .data_in (data_in),
      .byte_cnt(byte_cnt),
      .poly_sel(poly_sel),
      .crc_out (core_res),
      .done    (done),
      .busy    (busy)
    );
  end else begin : g_unrolled
    crc_unrolled_core #(
      .ACC_W(ACC_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)
    ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .acc_in  (acc_in[ACC_W-1:0]),
      .data_in (data_in),
      .byte_cnt(byte_cnt),
      .poly_sel(poly_sel),
      .crc_out (core_res),
      .done    (done),
      .busy    (busy)
    );
  end

  assign result = {{(DATA_W-ACC_W){1'b0}}, core_res};

endmodule

// File: rtl/crc_accum_chk.sv
module crc_accum_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned NBYTES = 8,
  parameter bit          SERIAL = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CNT_W-1:0]  byte_cnt,
  input logic [DATA_W-1:0] result,
  input logic              done,
  input logic              busy
);

  // R3: every accepted request carries a legal count
  a_r3_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |-> (byte_cnt >= CNT_W'(1) && byte_cnt <= CNT_W'(NBYTES)));

  // R8: the output holds unless a completion is being reported
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || $stable(result)));

  if (SERIAL) begin : g_ser
    // R5: completion is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
    // R5: completion only follows a busy interval
    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));
    // R6: busy drops exactly when done rises
    a_r6_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
    // R6: an accepted request makes the engine busy
    a_r6_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
  end else begin : g_unr
    // R5: unrolled completion follows the request by one cycle
    a_r5_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(start));
    // R6: the unrolled engine is never busy
    a_r6_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !busy);
  end

endmodule

bind crc_accum_unit crc_accum_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .NBYTES(NUM_BYTES), .SERIAL(SERIAL_MODE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .byte_cnt(byte_cnt),
  .result  (result),
  .done    (done),
  .busy    (busy)
);

// File: tb/test_crc_accum_unit.sv
`timescale 1ns/1ps
module test_crc_accum_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        start = 1'b0;
  logic [63:0] acc_in = '0;
  logic [63:0] data_in = '0;
  logic [3:0]  byte_cnt = 4'd1;
  logic        poly_sel = 1'b0;
  logic [63:0] result;
  logic        done, busy;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  // Reference model state
  bit          m_busy = 0, m_done = 0;
  int          m_left = 0;
  logic [31:0] m_res = '0, m_pend = '0;

  crc_accum_unit i_crc_accum_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .acc_in(acc_in),
    .data_in(data_in), .byte_cnt(byte_cnt), .poly_sel(poly_sel),
    .result(result), .done(done), .busy(busy)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] ref_crc(logic [31:0] a, logic [63:0] d, int n, bit s);
    logic [31:0] p = s ? 32'h82F63B78 : 32'hEDB88320;
    logic [31:0] c = a;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        bit fb = c[0] ^ d[8*i+b];
        c = c >> 1;
        if (fb) c = c ^ p;
      end
    end
    return c;
  endfunction

  function automatic logic [63:0] lane_mask(int n);
    return (n >= 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8*n)) - 64'd1);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_left = 0; m_res = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; m_res = m_pend;
        end
      end else if (start) begin
        m_busy = 1; m_left = byte_cnt;
        m_pend = ref_crc(acc_in[31:0], data_in, byte_cnt, poly_sel);
      end
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    check("R5 done", {63'd0, done}, {63'd0, m_done});
    check("R6 busy", {63'd0, busy}, {63'd0, m_busy});
    check("R1 R2 R3 R4 R8 result", result, {32'd0, m_res});
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic run_op(logic [63:0] a, logic [63:0] d, int n, bit s);
    @(negedge clk);
    start = 1'b1; acc_in = a; data_in = d & lane_mask(n); byte_cnt = 4'(n); poly_sel = s;
    @(negedge clk);
    start = 1'b0;
    repeat (n + 1) @(negedge clk);
  endtask

  initial begin
    logic [31:0] r1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 reset done", {63'd0, done}, 64'd0);
    check("R7 reset busy", {63'd0, busy}, 64'd0);
    check("R7 reset result", result, 64'd0);
    rst_n = 1'b1;

    // R1 R3: "123456789" as 8 bytes + 1 byte, seeded and finished by the bench
    run_op(64'hFFFF_FFFF, 64'h3837363534333231, 8, 1'b0);
    r1 = result[31:0];
    run_op({32'h0, r1}, 64'h39, 1, 1'b0);
    check("R1 crc32 check value", {32'd0, ~result[31:0]}, 64'h0000_0000_CBF4_3926);

    // R2: same message with the Castagnoli polynomial
    run_op(64'hFFFF_FFFF, 64'h3837363534333231, 8, 1'b1);
    r1 = result[31:0];
    run_op({32'h0, r1}, 64'h39, 1, 1'b1);
    check("R2 crc32c check value", {32'd0, ~result[31:0]}, 64'h0000_0000_E306_9283);

    // R1: zero remainder and zero byte stay zero (no inversion)
    run_op(64'h0, 64'h0, 4, 1'b0);
    check("R1 no inversion zero", result, 64'd0);

    // R4: upper accumulator half is ignored, upper result half is zero
    run_op(64'hDEAD_BEEF_1234_5678, 64'hA5, 1, 1'b0);
    check("R4 upper ignored", result, {32'd0, ref_crc(32'h1234_5678, 64'hA5, 1, 1'b0)});

    // R6: second start while busy is ignored
    @(negedge clk);
    start = 1'b1; acc_in = 64'h1111_2222; data_in = 64'h0102030405060708; byte_cnt = 4'd8; poly_sel = 1'b1;
    @(negedge clk);
    acc_in = 64'h7777_8888; data_in = 64'hFF; byte_cnt = 4'd1; poly_sel = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    check("R6 start while busy ignored", result,
          {32'd0, ref_crc(32'h1111_2222, 64'h0102030405060708, 8, 1'b1)});

    // R3 R5 R8: random operands, every count and both polynomials
    for (int k = 0; k < 300; k++) begin
      int n = 1 + (k % 8);
      run_op({$urandom, $urandom}, {$urandom, $urandom}, n, k[3]);
    end

    // R6: start held high with changing operands
    @(negedge clk);
    start = 1'b1;
    for (int k = 0; k < 200; k++) begin
      int n = 1 + ($urandom % 8);
      acc_in = {$urandom, $urandom};
      data_in = {$urandom, $urandom} & lane_mask(n);
      byte_cnt = 4'(n);
      poly_sel = $urandom % 2;
      @(negedge clk);
    end
    start = 1'b0;
    repeat (12) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule